// File: doc/BRIEF.md
# Test Access Port Controller with Addressed Debug Register Path

This block is a boundary-scan test access port controller. It implements the sixteen-state controller that TMS steers on each rising edge of TCK, and a 6-bit instruction register. A decoder uses the instruction to choose which data register sits between TDI and TDO. There are four paths: an external boundary-scan chain, a one-bit bypass stage, a fixed 32-bit identification code, and a 32-bit debug data register.

The debug path is reached through a family of opcodes that begin with binary `10`. The four low bits of the opcode name one of sixteen debug registers, and they appear on a parallel address port. In Capture-DR the block asserts a read strobe and loads the addressed register's value into the shift register. In Update-DR the block asserts a single write strobe on the falling edge of TCK and presents the shifted word. The boundary cells and the registers behind the debug port belong to other blocks. This block only provides the strobes, the mode flag and the serial path they need.

Top module: `jdbg_tap`

## Requirements
- R1: The controller follows the standard TMS state graph on rising TCK edges. Five consecutive rising edges with TMS high bring it to Test-Logic-Reset from any state.
- R2: Asserting `trst_n` low, or passing through Test-Logic-Reset, makes the active instruction IDCODE (binary 011111).
- R3: Capture-IR loads binary 000001 into the instruction shift stage. Shift-IR moves that stage toward TDO one bit per edge, least significant bit first, so the first six TDO bits read 1,0,0,0,0,0.
- R4: Under IDCODE, Capture-DR loads the 32-bit identification parameter, which is shifted out least significant bit first. The bits shifted in on TDI never change the value that a later capture returns.
- R5: Under BYPASS (binary 111111), a single stage sits between TDI and TDO and captures 0. An n-bit scan therefore returns a leading 0 followed by the input delayed by one bit.
- R6: Every opcode that is not 000000, 000001, 011111, 111111 or of the form 10xxxx behaves exactly like BYPASS. This includes 11xxxx values other than 111111.
- R7: Under opcode 10SSSS, `dbg_addr` equals SSSS. In Capture-DR, `dbg_rd` is high and the 32-bit word on `dbg_rdata` is loaded into the shift register. That word is then shifted out least significant bit first.
- R8: Under opcode 10SSSS, `dbg_wr` rises on the falling TCK edge in Update-DR and stays high for one TCK period, so exactly one rising edge samples it. Throughout that period `dbg_wdata` holds the 32 bits shifted in, with the first bit shifted in at bit 0.
- R9: Under 000000 (EXTEST) and 000001 (SAMPLE), the chain port is the scan path. `bs_si` follows TDI, `bs_so` feeds TDO, `bs_capture` and `bs_shift` mark Capture-DR and Shift-DR, and `bs_update` rises on the falling edge in Update-DR. `bs_extest` is high only for 000000.
- R10: TDO and `tdo_en` change on falling TCK edges. `tdo_en` is high only while the controller is in Shift-IR or Shift-DR, and both outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | Output enable for TDO |
| bs_si | output | 1 | Serial input to the boundary chain |
| bs_so | input | 1 | Serial output of the boundary chain |
| bs_capture | output | 1 | Chain capture enable |
| bs_shift | output | 1 | Chain shift enable |
| bs_update | output | 1 | Chain update strobe, rises on falling TCK |
| bs_extest | output | 1 | Chain drives pins (EXTEST active) |
| dbg_addr | output | 4 | Debug register address taken from the opcode |
| dbg_rd | output | 1 | Debug read strobe during Capture-DR |
| dbg_rdata | input | 32 | Value of the addressed debug register |
| dbg_wr | output | 1 | Debug write strobe |
| dbg_wdata | output | 32 | Value to write to the addressed debug register |

## Verification
After the rising edge that enters Shift-IR or Shift-DR, the falling edge of the same cycle presents the first captured bit on TDO. The bench samples each TDO bit a quarter period after that falling edge, before the next rising edge shifts the stage. The debug write strobe is produced on the falling edge inside Update-DR, so the bench's register model samples it on the rising edge that leaves Update-DR. Register contents and the write count are compared only after the scan has returned to Run-Test/Idle. An instruction takes effect one half cycle after the rising edge that enters Update-IR, and every data scan starts from Run-Test/Idle after that point.

// File: rtl/jdbg_pkg.sv
package jdbg_pkg;

  localparam int IR_W   = 6;
  localparam int ADDR_W = 4;

  localparam logic [IR_W-1:0] OP_EXTEST = 6'b000000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 6'b000001;
  localparam logic [IR_W-1:0] OP_IDCODE = 6'b011111;
  localparam logic [IR_W-1:0] OP_BYPASS = 6'b111111;
  localparam logic [IR_W-1:0] IR_CAPTURE_PATTERN = 6'b000001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {PATH_BSC, PATH_BYP, PATH_ID, PATH_DBG} dr_path_t;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic tms);
    tap_state_t n;
    case (s)
      ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
      default:   n = tms ? ST_SEL_DR : ST_RTI;
    endcase
    return n;
  endfunction

  function automatic dr_path_t decode_op(input logic [IR_W-1:0] op);
    dr_path_t p;
    if (op[IR_W-1 -: 2] == 2'b10)                 p = PATH_DBG;
    else if (op == OP_EXTEST || op == OP_SAMPLE)  p = PATH_BSC;
    else if (op == OP_IDCODE)                     p = PATH_ID;
    else                                          p = PATH_BYP;
    return p;
  endfunction

endpackage

// File: rtl/jdbg_tap_fsm.sv
module jdbg_tap_fsm
  import jdbg_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);

  localparam int RESET_RUN = 5;
  localparam int CNT_W = $clog2(RESET_RUN + 1);

  logic [CNT_W-1:0] tms_run;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= tap_next(state, tms);
  end

  // consecutive TMS-high count, used only to check the reset guarantee
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                          tms_run <= '0;
    else if (!tms)                        tms_run <= '0;
    else if (tms_run != CNT_W'(RESET_RUN)) tms_run <= tms_run + 1'b1;
  end

  a_r1_five_high_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (tms_run == CNT_W'(RESET_RUN)) |-> (state == ST_TLR));

  a_r1_tlr_holds: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR && tms) |=> (state == ST_TLR));

endmodule

// File: rtl/jdbg_ir.sv
module jdbg_ir
  import jdbg_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_sr <= IR_CAPTURE_PATTERN;
    else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE_PATTERN;
    else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_q <= OP_IDCODE;
    else if (state == ST_TLR)    ir_q <= OP_IDCODE;
    else if (state == ST_UPD_IR) ir_q <= ir_sr;
  end

  assign ir_so = ir_sr[0];

  a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE_PATTERN));

  a_r2_idle_reset_idcode: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR && $past(state == ST_TLR)) |-> (ir_q == OP_IDCODE));

endmodule

// File: rtl/jdbg_dr.sv
module jdbg_dr
  import jdbg_pkg::*;
#(
  parameter int          DR_W    = 32,
  parameter logic [31:0] ID_CODE = 32'h1A5E_C0DF
)(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_t      state,
  input  dr_path_t        path,
  input  logic            tdi,
  input  logic            bs_so,
  input  logic [DR_W-1:0] dbg_rdata,
  output logic            dr_so,
  output logic            dbg_wr,
  output logic [DR_W-1:0] dbg_wdata,
  output logic            bs_update
);

  logic [DR_W-1:0] wide_sr;
  logic            byp_q;
  logic            upd_q;
  logic            wide_sel;

  assign wide_sel = (path == PATH_ID) || (path == PATH_DBG);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      wide_sr <= '0;
    end else if (state == ST_CAP_DR) begin
      if (path == PATH_ID)       wide_sr <= DR_W'(ID_CODE);
      else if (path == PATH_DBG) wide_sr <= dbg_rdata;
    end else if (state == ST_SH_DR && wide_sel) begin
      wide_sr <= {tdi, wide_sr[DR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                                      byp_q <= 1'b0;
    else if (state == ST_CAP_DR && path == PATH_BYP)  byp_q <= 1'b0;
    else if (state == ST_SH_DR && path == PATH_BYP)   byp_q <= tdi;
  end

  // update actions take place on the falling edge inside Update-DR
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      upd_q     <= 1'b0;
      dbg_wdata <= '0;
    end else begin
      upd_q <= (state == ST_UPD_DR);
      if (state == ST_UPD_DR && path == PATH_DBG) dbg_wdata <= wide_sr;
    end
  end

  assign dbg_wr    = upd_q && (path == PATH_DBG);
  assign bs_update = upd_q && (path == PATH_BSC);

  always_comb begin
    case (path)
      PATH_BSC: dr_so = bs_so;
      PATH_BYP: dr_so = byp_q;
      default:  dr_so = wide_sr[0];
    endcase
  end

  a_r5_bypass_captures_zero: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && path == PATH_BYP) |=> (dr_so == 1'b0));

  a_r4_id_capture: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && path == PATH_ID) |=> (wide_sr == DR_W'(ID_CODE)));

endmodule

// File: rtl/jdbg_tap.sv
module jdbg_tap
  import jdbg_pkg::*;
#(
  parameter int          DR_W    = 32,
  parameter logic [31:0] ID_CODE = 32'h1A5E_C0DF
)(
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  output logic              bs_si,
  input  logic              bs_so,
  output logic              bs_capture,
  output logic              bs_shift,
  output logic              bs_update,
  output logic              bs_extest,
  output logic [ADDR_W-1:0] dbg_addr,
  output logic              dbg_rd,
  input  logic [DR_W-1:0]   dbg_rdata,
  output logic              dbg_wr,
  output logic [DR_W-1:0]   dbg_wdata
);

  tap_state_t      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_so;
  logic            dr_so;
  dr_path_t        path;

  jdbg_tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
  );

  jdbg_ir u_ir (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
    .ir_q(ir_q), .ir_so(ir_so)
  );

  assign path = decode_op(ir_q);

  jdbg_dr #(.DR_W(DR_W), .ID_CODE(ID_CODE)) u_dr (
    .tck(tck), .trst_n(trst_n), .state(state), .path(path), .tdi(tdi),
    .bs_so(bs_so), .dbg_rdata(dbg_rdata), .dr_so(dr_so),
    .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata), .bs_update(bs_update)
  );

  assign bs_si      = tdi;
  assign bs_capture = (state == ST_CAP_DR) && (path == PATH_BSC);
  assign bs_shift   = (state == ST_SH_DR)  && (path == PATH_BSC);
  assign bs_extest  = (ir_q == OP_EXTEST);
  assign dbg_addr   = ir_q[ADDR_W-1:0];
  assign dbg_rd     = (state == ST_CAP_DR) && (path == PATH_DBG);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= (state == ST_SH_IR) ? ir_so : dr_so;
      tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end

  a_r8_write_in_update: assert property (@(posedge tck) disable iff (!trst_n)
    dbg_wr |-> (state == ST_UPD_DR));

  a_r10_enable_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

  a_r9_strobes_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bs_capture, bs_shift, dbg_rd}));

endmodule

// File: tb/jdbg_tap_test.sv
module jdbg_tap_test;

  localparam int          PERIOD = 20;
  localparam logic [31:0] ID     = 32'h1A5E_C0DF;

  logic        tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic        tdo, tdo_en, bs_si, bs_so, bs_capture, bs_shift, bs_update, bs_extest;
  logic [3:0]  dbg_addr;
  logic        dbg_rd, dbg_wr;
  logic [31:0] dbg_rdata, dbg_wdata;

  jdbg_tap #(.DR_W(32), .ID_CODE(ID)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .bs_si(bs_si), .bs_so(bs_so), .bs_capture(bs_capture), .bs_shift(bs_shift),
    .bs_update(bs_update), .bs_extest(bs_extest), .dbg_addr(dbg_addr),
    .dbg_rd(dbg_rd), .dbg_rdata(dbg_rdata), .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata)
  );

  // debug register model behind the parallel port
  logic [31:0] mem [16];
  int          wr_cnt = 0;
  int          bsu_cnt = 0;
  logic [3:0]  chain;

  initial for (int k = 0; k < 16; k++) mem[k] = 32'hC0DE_0000 + k * 32'h111;
  assign dbg_rdata = mem[dbg_addr];

  always @(posedge tck) if (dbg_wr) begin
    mem[dbg_addr] <= dbg_wdata;
    wr_cnt <= wr_cnt + 1;
  end

  always @(posedge tck) begin
    if (bs_capture)    chain <= 4'hA;
    else if (bs_shift) chain <= {bs_si, chain[3:1]};
    if (bs_update) bsu_cnt <= bsu_cnt + 1;
  end
  assign bs_so = chain[0];

  // scoreboard
  typedef struct { string req; logic [31:0] val; } item_t;
  item_t exp_q[$];
  item_t act_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic expect_val(input string req, input logic [31:0] v);
    item_t it; it.req = req; it.val = v; exp_q.push_back(it);
  endtask

  task automatic observe(input logic [31:0] v);
    item_t it; it.req = ""; it.val = v; act_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      item_t e, a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      n_cmp++;
      if (a.val !== e.val) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", e.req, a.val, e.val);
      end
    end
  endtask

  always @(negedge tck) drain();

  task automatic summary();
    if (!done) begin
      done = 1;
      drain();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // one TCK cycle; TDO is sampled before the rising edge
  task automatic tick(input logic m, input logic d, output logic so, output logic en);
    tms = m; tdi = d;
    #(PERIOD / 4);
    so = tdo; en = tdo_en;
    #(PERIOD / 4) tck = 1'b1;
    #(PERIOD / 2) tck = 1'b0;
  endtask

  task automatic nav(input logic m);
    logic s, e;
    tick(m, 1'b0, s, e);
  endtask

  task automatic scan_ir(input logic [5:0] op, output logic [5:0] cap);
    logic s, e;
    nav(1); nav(1); nav(0); nav(0);
    for (int i = 0; i < 6; i++) begin
      tick(i == 5, op[i], s, e);
      cap[i] = s;
    end
    nav(1); nav(0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din,
                         output logic [31:0] dout, output logic en_all);
    logic s, e;
    dout = '0; en_all = 1'b1;
    nav(1); nav(0); nav(0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], s, e);
      dout[i] = s;
      en_all &= e;
    end
    nav(1); nav(0);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    expect_val(req, exp);
    observe(act);
  endtask

  logic [5:0]  cap;
  logic [31:0] dout;
  logic        en, s0, e0;
  int          w0;

  initial begin
    #(PERIOD * 2);
    check("R10 reset tdo_en", {31'b0, tdo_en}, 32'd0);
    check("R10 reset tdo", {31'b0, tdo}, 32'd0);
    trst_n = 1'b1;
    nav(1); nav(0);

    // R2: reset instruction is IDCODE
    scan_dr(32, 32'h0, dout, en);
    check("R2 idcode after trst", dout, ID);
    check("R10 enable during shift", {31'b0, en}, 32'd1);
    tick(0, 0, s0, e0);
    check("R10 enable off in idle", {31'b0, e0}, 32'd0);

    // R3: capture-IR pattern
    scan_ir(6'b111111, cap);
    check("R3 capture pattern", {26'b0, cap}, 32'h1);

    // R5: bypass
    scan_dr(8, 32'hB6, dout, en);
    check("R5 bypass delay", dout, 32'h6C);

    // R6: undefined opcodes act as bypass
    scan_ir(6'b110101, cap);
    scan_dr(8, 32'h5A, dout, en);
    check("R6 opcode 110101 bypass", dout, 32'hB4);
    scan_ir(6'b001010, cap);
    scan_dr(8, 32'hFF, dout, en);
    check("R6 opcode 001010 bypass", dout, 32'hFE);

    // R4: idcode unaffected by shifted-in data
    scan_ir(6'b011111, cap);
    scan_dr(32, 32'hFFFF_0000, dout, en);
    check("R4 idcode first", dout, ID);
    scan_dr(32, 32'h1234_0000, dout, en);
    check("R4 idcode after overwrite attempt", dout, ID);

    // R7 / R8: debug register 3
    scan_ir(6'b100011, cap);
    check("R7 address from opcode", {28'b0, dbg_addr}, 32'h3);
    w0 = wr_cnt;
    scan_dr(32, 32'h1234_5678, dout, en);
    check("R7 snapshot reg3", dout, 32'hC0DE_0333);
    check("R8 single write strobe", wr_cnt - w0, 32'd1);
    check("R8 reg3 written", mem[3], 32'h1234_5678);
    check("R8 reg10 untouched", mem[10], 32'hC0DE_0AAA);
    scan_dr(32, 32'h1234_5678, dout, en);
    check("R7 readback reg3", dout, 32'h1234_5678);

    // R7: another address
    scan_ir(6'b101010, cap);
    scan_dr(32, 32'h0BAD_F00D, dout, en);
    check("R7 snapshot reg10", dout, 32'hC0DE_0AAA);
    check("R8 reg10 written", mem[10], 32'h0BAD_F00D);

    // R9: boundary chain with EXTEST and SAMPLE
    scan_ir(6'b000000, cap);
    check("R9 extest flag", {31'b0, bs_extest}, 32'd1);
    w0 = bsu_cnt;
    scan_dr(4, 32'h5, dout, en);
    check("R9 chain capture out", dout, 32'hA);
    check("R9 chain shifted in", {28'b0, chain}, 32'h5);
    check("R9 one update strobe", bsu_cnt - w0, 32'd1);
    scan_ir(6'b000001, cap);
    check("R9 sample flag low", {31'b0, bs_extest}, 32'd0);
    scan_dr(4, 32'h3, dout, en);
    check("R9 sample chain out", dout, 32'hA);

    // R1: five TMS-high cycles from Shift-DR reach reset
    scan_ir(6'b100101, cap);
    nav(1); nav(0); nav(0);
    for (int i = 0; i < 5; i++) nav(1);
    nav(0);
    scan_dr(32, 32'h0, dout, en);
    check("R1 five-high reset then idcode", dout, ID);

    nav(0); nav(0);
    summary();
  end

endmodule